// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block watches a two-wire serial bus (data line and clock line, I2C-style) and uses it as evidence that the host processor is alive. Both lines are sampled with the system clock. The block restarts its timeout only after it sees a complete, well-formed transaction frame. A frame is a START condition followed later by a STOP condition, with at least one rising edge of the clock line in between. If no such frame arrives within the selected period, the block emits a one-cycle pulse toward the reset controller.

A two-bit period field selects one of three parameterized timeouts or turns the watchdog off. The host writes the field through a simple write strobe. A hardware lock input, held high, freezes the field against any change. An external hold input keeps the counter and the frame qualifier cleared while it is active, for example while the system is already in reset. Counting starts again from zero when the hold is released.

Top module: `bus_wdt`

## Requirements
- R1: After `rst_n` is released and before any write, `expire_pulse` is low and `sel_q` reads 2'b00.
- R2: With no valid frame, `expire_pulse` goes high for exactly one cycle every P cycles. P is PERIOD_A for `sel_q`=2'b00, PERIOD_B for 2'b01 and PERIOD_C for 2'b10.
- R3: With `sel_q`=2'b11 the watchdog is off and `expire_pulse` never goes high.
- R4: A valid frame restarts the count. A frame is a START (data line falls while the clock line is high), then at least one clock-line rising edge, then a STOP (data line rises while the clock line is high). A STOP applied at the pins in the cycle ending at clock edge M+1 is followed by the next pulse at edge M+3+P.
- R5: A START followed by a STOP with no clock-line rising edge between them does not restart the count.
- R6: A second START before the STOP restarts frame qualification and discards any clock-line rising edge seen earlier.
- R7: While `sys_hold` is high, no pulse occurs and the count stays at zero. If `sys_hold` is first seen low at edge N+1, the first pulse occurs at edge N+P.
- R8: Bus activity seen while `sys_hold` is high does not count toward a frame. A STOP after release, with no START after release, does not restart the count.
- R9: A write (`sel_wr_en` high, `sel_lock` low) loads `sel_wr_data` into `sel_q` on the next edge. The same edge restarts the count from zero under the new period.
- R10: While `sel_lock` is high, writes are ignored and `sel_q` keeps its value.
- R11: After each pulse the count reloads and runs again with no gap. The count never reaches the selected period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_hold | input | 1 | External hold; clears the counter and the frame qualifier while high |
| bus_sda | input | 1 | Bus data line (asynchronous) |
| bus_scl | input | 1 | Bus clock line (asynchronous) |
| sel_wr_en | input | 1 | Write strobe for the period field |
| sel_wr_data | input | 2 | Value to load into the period field |
| sel_lock | input | 1 | Write lock; blocks period field writes while high |
| sel_q | output | 2 | Current period field (00/01/10 = periods A/B/C, 11 = off) |
| expire_pulse | output | 1 | One-cycle timeout pulse toward the reset controller |

## Verification
A fault in the frame qualifier shows up as a pulse that arrives at the plain period instead of P cycles after the STOP, or the reverse. It is visible within one period of the offending bus activity. A counter that reloads wrong or uses the wrong limit moves the pulse edge by a fixed number of cycles, and a pulse that lasts too long shows up at once as an extra pulse. A period field that takes a locked write is visible on `sel_q` one cycle after the strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PSEL_A   = 2'b00,
    PSEL_B   = 2'b01,
    PSEL_C   = 2'b10,
    PSEL_OFF = 2'b11
  } psel_e;

  // Cycle count chosen by the period field; 0 means the watchdog is off.
  function automatic int unsigned period_of(psel_e s, int unsigned pa,
                                            int unsigned pb, int unsigned pc);
    case (s)
      PSEL_A:  return pa;
      PSEL_B:  return pb;
      PSEL_C:  return pc;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Bus events on synchronized samples: prev is one cycle older than now.
  function automatic logic is_start(logic sda_prev, logic sda_now, logic scl_now);
    return sda_prev & ~sda_now & scl_now;
  endfunction

  function automatic logic is_stop(logic sda_prev, logic sda_now, logic scl_now);
    return ~sda_prev & sda_now & scl_now;
  endfunction

  function automatic logic is_rise(logic prev, logic now);
    return ~prev & now;
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '1;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '1;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_kick_det.sv
module wdt_kick_det (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic sda,
  input  logic scl,
  output logic kick_o,
  output logic armed_o
);
  import wdt_pkg::*;

  logic sda_q, scl_q;
  logic armed_q, toggled_q;
  logic start_w, stop_w, rise_w;

  assign start_w = is_start(sda_q, sda, scl);
  assign stop_w  = is_stop(sda_q, sda, scl);
  assign rise_w  = is_rise(scl_q, scl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
    end
  end

  // armed: a START has been seen; toggled: clock line rose since that START
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      toggled_q <= 1'b0;
    end else if (hold) begin
      armed_q   <= 1'b0;
      toggled_q <= 1'b0;
    end else if (start_w) begin
      armed_q   <= 1'b1;
      toggled_q <= 1'b0;
    end else if (stop_w) begin
      armed_q   <= 1'b0;
      toggled_q <= 1'b0;
    end else if (rise_w && armed_q) begin
      toggled_q <= 1'b1;
    end
  end

  assign kick_o  = stop_w & armed_q & toggled_q & ~hold;
  assign armed_o = armed_q;
endmodule

// File: rtl/wdt_period_reg.sv
module wdt_period_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       lock,
  output logic [1:0] sel_o,
  output logic       accept_o
);
  logic [1:0] sel_q;

  assign accept_o = wr_en & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= 2'b00;
    else if (accept_o) sel_q <= wr_data;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned PERIOD_A = 2000,
  parameter int unsigned PERIOD_B = 8000,
  parameter int unsigned PERIOD_C = 32000,
  parameter int          CW       = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       pulse_o,
  output logic       cnt_zero_o,
  output logic       in_range_o
);
  import wdt_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit_w;
  logic          enabled_w, last_w, pulse_q;

  assign limit_w   = CW'(period_of(psel_e'(sel), PERIOD_A, PERIOD_B, PERIOD_C));
  assign enabled_w = (psel_e'(sel) != PSEL_OFF);
  assign last_w    = enabled_w & (cnt_q == limit_w - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (hold || restart || !enabled_w) begin
        cnt_q <= '0;
      end else if (last_w) begin
        cnt_q   <= '0;
        pulse_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign pulse_o    = pulse_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign in_range_o = !enabled_w || (cnt_q < limit_w);
endmodule

// File: rtl/bus_wdt.sv
module bus_wdt #(
  parameter int unsigned PERIOD_A    = 2000,
  parameter int unsigned PERIOD_B    = 8000,
  parameter int unsigned PERIOD_C    = 32000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_hold,
  input  logic       bus_sda,
  input  logic       bus_scl,
  input  logic       sel_wr_en,
  input  logic [1:0] sel_wr_data,
  input  logic       sel_lock,
  output logic [1:0] sel_q,
  output logic       expire_pulse
);
  localparam int unsigned PMAX = wdt_pkg::max3(PERIOD_A, PERIOD_B, PERIOD_C);
  localparam int          CW   = $clog2(PMAX + 1);

  logic [1:0] bus_raw_w, bus_syn_w;
  logic       kick_w, armed_w, accept_w;
  logic       cnt_zero_w, in_range_w;

  assign bus_raw_w = {bus_scl, bus_sda};

  wdt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (bus_raw_w),
    .q (bus_syn_w)
  );

  wdt_kick_det u_kick (
    .clk (clk),
    .rst_n (rst_n),
    .hold (sys_hold),
    .sda (bus_syn_w[0]),
    .scl (bus_syn_w[1]),
    .kick_o (kick_w),
    .armed_o (armed_w)
  );

  wdt_period_reg u_preg (
    .clk (clk),
    .rst_n (rst_n),
    .wr_en (sel_wr_en),
    .wr_data (sel_wr_data),
    .lock (sel_lock),
    .sel_o (sel_q),
    .accept_o (accept_w)
  );

  wdt_counter #(
    .PERIOD_A (PERIOD_A),
    .PERIOD_B (PERIOD_B),
    .PERIOD_C (PERIOD_C),
    .CW (CW)
  ) u_cnt (
    .clk (clk),
    .rst_n (rst_n),
    .hold (sys_hold),
    .restart (kick_w | accept_w),
    .sel (sel_q),
    .pulse_o (expire_pulse),
    .cnt_zero_o (cnt_zero_w),
    .in_range_o (in_range_w)
  );
endmodule

// File: rtl/bus_wdt_chk.sv
module bus_wdt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_hold,
  input logic       sel_lock,
  input logic [1:0] sel_q,
  input logic       expire_pulse,
  input logic       kick,
  input logic       armed,
  input logic       cnt_zero,
  input logic       in_range
);
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |=> !expire_pulse);

  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_q) == 2'b11) |-> !expire_pulse);

  assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt_zero);

  assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sys_hold) |-> (!expire_pulse && cnt_zero));

  assert_hold_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hold |=> !armed);

  assert_lock_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lock |=> $stable(sel_q));

  assert_count_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_range);
endmodule

bind bus_wdt bus_wdt_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .sys_hold (sys_hold),
  .sel_lock (sel_lock),
  .sel_q (sel_q),
  .expire_pulse (expire_pulse),
  .kick (kick_w),
  .armed (armed_w),
  .cnt_zero (cnt_zero_w),
  .in_range (in_range_w)
);

// File: tb/sim_bus_wdt.sv
module sim_bus_wdt;
  localparam int PA = 40;
  localparam int PB = 60;
  localparam int PC = 90;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_hold = 1'b1;
  logic       bus_sda = 1'b1;
  logic       bus_scl = 1'b1;
  logic       sel_wr_en = 1'b0;
  logic [1:0] sel_wr_data = 2'b00;
  logic       sel_lock = 1'b0;
  logic [1:0] sel_q;
  logic       expire_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_wdt #(.PERIOD_A(PA), .PERIOD_B(PB), .PERIOD_C(PC)) u0 (
    .clk (clk), .rst_n (rst_n), .sys_hold (sys_hold),
    .bus_sda (bus_sda), .bus_scl (bus_scl),
    .sel_wr_en (sel_wr_en), .sel_wr_data (sel_wr_data), .sel_lock (sel_lock),
    .sel_q (sel_q), .expire_pulse (expire_pulse)
  );

  // Monitor: every pulse must match the head of the expectation queue.
  always @(negedge clk) begin
    if (rst_n && expire_pulse && !done) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL unexpected pulse (R2/R3/R5/R7/R8): actual cycle %0d, expected none", cyc);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (e.at != cyc) begin
          errors++;
          $display("FAIL %s pulse: actual cycle %0d, expected %0d", e.tag, cyc, e.at);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_pulse(input int at, input string tag);
    exp_t e;
    e.at = at;
    e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic drain(input string tag);
    check(expq.size() == 0, tag, expq.size(), 0);
    expq.delete();
  endtask

  task automatic write_sel(input logic [1:0] v);
    sel_wr_en = 1'b1;
    sel_wr_data = v;
    tick(1);
    sel_wr_en = 1'b0;
  endtask

  task automatic hold_and_drain(input string tag);
    sys_hold = 1'b1;
    tick(5);
    drain(tag);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d, expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    int n, m, w;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state
    check(expire_pulse == 1'b0, "R1 pulse after reset", expire_pulse, 0);
    check(sel_q == 2'b00, "R1 period field after reset", sel_q, 0);
    tick(60); // hold is high: any pulse here is unexpected (R7)

    // R7, R2, R11: release hold, periodic pulses with period A
    n = cyc; sys_hold = 1'b0;
    expect_pulse(n + PA, "R7 first");
    expect_pulse(n + 2*PA, "R11 reload");
    expect_pulse(n + 3*PA, "R2 period A");
    wait_until(n + 3*PA + 5);
    hold_and_drain("R2 missing pulses");

    // R4: valid frame restarts the count
    n = cyc; sys_hold = 1'b0;
    tick(10);
    bus_sda = 1'b0; tick(2);
    bus_scl = 1'b0; tick(2);
    bus_scl = 1'b1; tick(2);
    m = cyc; bus_sda = 1'b1;
    expect_pulse(m + 3 + PA, "R4 after frame");
    expect_pulse(m + 3 + 2*PA, "R4 reload");
    wait_until(m + 3 + 2*PA + 5);
    hold_and_drain("R4 missing pulses");

    // R5: START then STOP with no clock rise
    n = cyc; sys_hold = 1'b0;
    tick(10);
    bus_sda = 1'b0; tick(4);
    bus_sda = 1'b1;
    expect_pulse(n + PA, "R5 no restart");
    wait_until(n + PA + 10);
    hold_and_drain("R5 missing pulses");

    // R6: repeated START discards the earlier clock rise
    n = cyc; sys_hold = 1'b0;
    tick(10);
    bus_sda = 1'b0; tick(2);
    bus_scl = 1'b0; tick(2);
    bus_sda = 1'b1; tick(2);
    bus_scl = 1'b1; tick(2);
    bus_sda = 1'b0; tick(2);
    bus_sda = 1'b1;
    expect_pulse(n + PA, "R6 no restart");
    wait_until(n + PA + 30);
    hold_and_drain("R6 missing pulses");

    // R8: START and clock rise during hold are forgotten
    bus_sda = 1'b0; tick(2);
    bus_scl = 1'b0; tick(2);
    bus_scl = 1'b1; tick(2);
    n = cyc; sys_hold = 1'b0;
    tick(3);
    bus_sda = 1'b1;
    expect_pulse(n + PA, "R8 no restart");
    wait_until(n + PA + 10);
    hold_and_drain("R8 missing pulses");

    // R9: write period B (01) with lock low
    write_sel(2'b01);
    check(sel_q == 2'b01, "R9 write accepted", sel_q, 1);
    n = cyc; sys_hold = 1'b0;
    expect_pulse(n + PB, "R9 period B");
    expect_pulse(n + 2*PB, "R2 period B");
    wait_until(n + 2*PB + 5);
    hold_and_drain("R9 missing pulses");

    // R10: write blocked by lock
    sel_lock = 1'b1;
    write_sel(2'b10);
    check(sel_q == 2'b01, "R10 locked write ignored", sel_q, 1);
    n = cyc; sys_hold = 1'b0;
    expect_pulse(n + PB, "R10 period unchanged");
    wait_until(n + PB + 5);
    hold_and_drain("R10 missing pulses");
    sel_lock = 1'b0;

    // R2: period C (10)
    write_sel(2'b10);
    check(sel_q == 2'b10, "R2 period C selected", sel_q, 2);
    n = cyc; sys_hold = 1'b0;
    expect_pulse(n + PC, "R2 period C");
    expect_pulse(n + 2*PC, "R11 period C reload");
    wait_until(n + 2*PC + 5);
    hold_and_drain("R2 period C missing");

    // R9: a write while counting restarts under the new period
    n = cyc; sys_hold = 1'b0;
    wait_until(n + 20);
    write_sel(2'b00);
    expect_pulse(n + 21 + PA, "R9 restart on write");
    expect_pulse(n + 21 + 2*PA, "R9 new period reload");
    wait_until(n + 21 + 2*PA + 5);
    hold_and_drain("R9 restart missing");

    // R3: field 11 turns the watchdog off; re-enable afterwards
    write_sel(2'b11);
    check(sel_q == 2'b11, "R3 off selected", sel_q, 3);
    n = cyc; sys_hold = 1'b0;
    wait_until(n + 300);
    w = cyc;
    write_sel(2'b00);
    expect_pulse(w + 1 + PA, "R3 re-enabled");
    wait_until(w + 1 + PA + 5);
    hold_and_drain("R3 missing pulses");

    finish_run();
  end
endmodule